// File: doc/BRIEF.md
# Endpoint Base Address Register Bank with Address Decode

This block holds the six base address slots of an endpoint's type 0 configuration header and decodes incoming request addresses against them. Configuration software reaches the slots through a dword-addressed read/write port with byte enables. Each slot's kind (unused, 32-bit memory, IO, or the lower or upper half of a 64-bit memory window), region size and prefetch attribute are fixed by parameters. Only the address bits a region's size allows can be written, so software can write all ones, read back the size mask, and then program a real base.

The decode side takes a request kind (memory or IO) and an address. It returns a one-hot vector naming the slot whose window contains the address, plus the address offset inside that window. A slot can only claim a request of its own kind, and only when the matching space-enable bit from the command register is set.

Top module: `bar_decode_bank`

## Requirements
- R1: The slots sit at dword offsets 4 to 9 (byte offsets 0x10 to 0x24). Any other dword offset reads 0, and a write there changes no slot.
- R2: Read-only low bits: bit 0 reads 1 for an IO slot and 0 for a memory slot. A memory slot reads bits 2:1 as 00 for 32-bit decode or 10 for 64-bit decode, and bit 3 as its prefetch flag.
- R3: Bits below log2 of the region size read 0. Writing 0xFFFFFFFF and reading back gives the size mask OR the attribute bits (4 KiB 32-bit memory: 0xFFFFF000; 256 B IO: 0xFFFFFF01; 1 MiB prefetchable 64-bit: 0xFFF0000C; 64 KiB prefetchable 32-bit: 0xFFFF0008).
- R4: A write updates only the bytes whose enable is 1. Enable bit k covers data bits 8k+7:8k, so enable bit 0 covers the attribute byte.
- R5: After reset every writable bit is 0, so a slot reads only its attribute bits.
- R6: An unimplemented slot reads all zeros and ignores writes.
- R7: A 64-bit window uses an even slot with the next slot. The upper slot holds address bits 63:32, is writable in all 32 bits, and never reports a hit of its own.
- R8: A hit needs req_valid, a request kind equal to the slot kind, and the matching enable (cmd_mem_en for memory, cmd_io_en for IO).
- R9: A slot hits when the request address, masked by the slot's size mask, equals its programmed base. A 32-bit slot also needs address bits 63:32 to be zero. A 64-bit pair compares all 64 bits.
- R10: hit_vec is one-hot or zero. When windows overlap, the lowest-numbered matching slot wins. With no match, hit_vec and hit_offset are 0.
- R11: hit_offset equals the request address bits below the region size of the winning slot, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | CFG_AW | Configuration dword offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data for cfg_dw (combinational) |
| cmd_mem_en | input | 1 | Memory space enable from the command register |
| cmd_io_en | input | 1 | IO space enable from the command register |
| req_valid | input | 1 | Request address is valid |
| req_is_io | input | 1 | 1 = IO request, 0 = memory request |
| req_addr | input | AW | Request address |
| hit_vec | output | 6 | One-hot slot hit |
| hit_offset | output | AW | Offset inside the hit window |

## Verification
A stored base bit that is wrong appears on cfg_rdata in the same cycle its dword is selected. It also changes hit_vec and hit_offset for any address near that window, with no added delay, because both paths are combinational from the stored registers. A wrong size mask or wrong attribute constant appears in the read-back of an all-ones write and at the window boundary addresses. For this reason the bench compares read data and decode results against a model on every clock, and probes addresses just inside and just outside each window.

// File: rtl/bar_bank_pkg.sv
`timescale 1ns/1ps
package bar_bank_pkg;

   localparam int unsigned SLOT_COUNT   = 6;
   localparam int unsigned SLOT_BASE_DW = 4;
   localparam int unsigned LOG2_W       = 6;

   typedef enum logic [2:0] {
      ROLE_NONE,
      ROLE_MEM32,
      ROLE_IO,
      ROLE_MEM64_LO,
      ROLE_MEM64_HI
   } slot_role_e;

   function automatic logic [31:0] low_ones(input int unsigned n);
      logic [63:0] t;
      t = (64'd1 << n) - 64'd1;
      return t[31:0];
   endfunction

   function automatic logic [31:0] writable_mask(input slot_role_e r, input int unsigned lg);
      case (r)
         ROLE_NONE:     return 32'h0;
         ROLE_MEM64_HI: return 32'hFFFF_FFFF;
         default:       return ~low_ones(lg);
      endcase
   endfunction

   function automatic logic [31:0] attr_bits(input slot_role_e r, input logic pref);
      case (r)
         ROLE_IO:       return 32'h1;
         ROLE_MEM32:    return {28'h0, pref, 3'b000};
         ROLE_MEM64_LO: return {28'h0, pref, 3'b100};
         default:       return 32'h0;
      endcase
   endfunction

   function automatic slot_role_e pick_role(input int unsigned idx, input logic [5:0] present,
                                            input logic [5:0] io, input logic [5:0] wide);
      if ((idx % 2 == 1) && wide[idx-1] && present[idx-1]) return ROLE_MEM64_HI;
      if (!present[idx]) return ROLE_NONE;
      if (io[idx])       return ROLE_IO;
      if (wide[idx])     return ROLE_MEM64_LO;
      return ROLE_MEM32;
   endfunction

endpackage

// File: rtl/bar_slot_reg.sv
`timescale 1ns/1ps
module bar_slot_reg
   import bar_bank_pkg::*;
#(
   parameter slot_role_e  ROLE      = ROLE_NONE,
   parameter int unsigned SIZE_LOG2 = 12,
   parameter logic        PREFETCH  = 1'b0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_sel,
   input  logic [31:0] wdata,
   input  logic [3:0]  be,
   output logic [31:0] rd_word,
   output logic [31:0] addr_bits,
   output logic [31:0] size_mask
);

   localparam logic [31:0] WMASK = writable_mask(ROLE, SIZE_LOG2);
   localparam logic [31:0] ATTR  = attr_bits(ROLE, PREFETCH);

   logic [31:0] lane_mask;
   logic [31:0] held;

   always_comb begin
      for (int b = 0; b < 4; b++) lane_mask[b*8 +: 8] = {8{be[b]}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (wr_sel)
         held <= ((held & ~lane_mask) | (wdata & lane_mask)) & WMASK;
   end

   assign addr_bits = held;
   assign rd_word   = held | ATTR;
   assign size_mask = WMASK;

   // R1: a slot not addressed by a write keeps its value
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> $stable(rd_word));

   // R4: a write with no byte enabled changes nothing
   p_no_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && be == 4'h0) |=> $stable(rd_word));

endmodule

// File: rtl/bar_window_match.sv
`timescale 1ns/1ps
module bar_window_match
   import bar_bank_pkg::*;
#(
   parameter slot_role_e  ROLE = ROLE_NONE,
   parameter int unsigned AW   = 64
)(
   input  logic          req_valid,
   input  logic          req_is_io,
   input  logic [AW-1:0] req_addr,
   input  logic          mem_en,
   input  logic          io_en,
   input  logic [31:0]   lo_addr,
   input  logic [31:0]   lo_mask,
   input  logic [31:0]   hi_addr,
   output logic          hit,
   output logic [AW-1:0] offset
);

   localparam logic ACTIVE = (ROLE == ROLE_MEM32) || (ROLE == ROLE_IO) || (ROLE == ROLE_MEM64_LO);
   localparam logic IS_IO  = (ROLE == ROLE_IO);
   localparam logic WIDE   = (ROLE == ROLE_MEM64_LO);

   logic [63:0] addr64, base64, mask64, off64;
   logic        kind_ok;

   always_comb begin
      addr64  = 64'(req_addr);
      mask64  = {32'hFFFF_FFFF, lo_mask};
      base64  = {(WIDE ? hi_addr : 32'h0), lo_addr};
      kind_ok = IS_IO ? (req_is_io && io_en) : (!req_is_io && mem_en);
      hit     = ACTIVE && req_valid && kind_ok && ((addr64 & mask64) == base64);
      off64   = addr64 & ~mask64;
      offset  = off64[AW-1:0];
   end

endmodule

// File: rtl/bar_decode_bank.sv
`timescale 1ns/1ps
module bar_decode_bank
   import bar_bank_pkg::*;
#(
   parameter int unsigned AW            = 64,
   parameter int unsigned CFG_AW        = 10,
   parameter logic [5:0]  SLOT_PRESENT  = 6'b011111,
   parameter logic [5:0]  SLOT_IO       = 6'b000010,
   parameter logic [5:0]  SLOT_WIDE     = 6'b000100,
   parameter logic [5:0]  SLOT_PREFETCH = 6'b010100,
   parameter logic [SLOT_COUNT*LOG2_W-1:0] SLOT_LOG2 = {6'd0, 6'd16, 6'd0, 6'd20, 6'd8, 6'd12}
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_dw,
   input  logic [31:0]       cfg_wdata,
   input  logic [3:0]        cfg_be,
   output logic [31:0]       cfg_rdata,
   input  logic              cmd_mem_en,
   input  logic              cmd_io_en,
   input  logic              req_valid,
   input  logic              req_is_io,
   input  logic [AW-1:0]     req_addr,
   output logic [5:0]        hit_vec,
   output logic [AW-1:0]     hit_offset
);

   if (AW < 33 || AW > 64) begin : g_bad_aw
      $error("AW must lie in 33..64");
   end
   if (CFG_AW < 4) begin : g_bad_cfg_aw
      $error("CFG_AW too small to reach the slot offsets");
   end

   logic [31:0]   slot_rd   [SLOT_COUNT];
   logic [31:0]   slot_addr [SLOT_COUNT];
   logic [31:0]   slot_mask [SLOT_COUNT];
   logic [AW-1:0] slot_off  [SLOT_COUNT];
   logic [SLOT_COUNT-1:0] slot_wr, raw_hit, upper_map;

   for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
      localparam slot_role_e  ROLE = pick_role(i, SLOT_PRESENT, SLOT_IO, SLOT_WIDE);
      localparam int unsigned LG   = SLOT_LOG2[i*LOG2_W +: LOG2_W];

      if (SLOT_WIDE[i] && (i % 2 == 1)) begin : g_bad_odd
         $error("a 64-bit window must start on an even slot");
      end
      if (SLOT_WIDE[i] && SLOT_IO[i]) begin : g_bad_io64
         $error("an IO slot cannot be 64-bit");
      end
      if (ROLE == ROLE_IO && (LG < 2 || LG > 31)) begin : g_bad_io_size
         $error("IO region log2 size out of range");
      end
      if ((ROLE == ROLE_MEM32 || ROLE == ROLE_MEM64_LO) && (LG < 4 || LG > 31)) begin : g_bad_mem_size
         $error("memory region log2 size out of range");
      end

      assign slot_wr[i]   = cfg_wr && (cfg_dw == CFG_AW'(SLOT_BASE_DW + i));
      assign upper_map[i] = (ROLE == ROLE_MEM64_HI);

      bar_slot_reg #(
         .ROLE      (ROLE),
         .SIZE_LOG2 (LG),
         .PREFETCH  (SLOT_PREFETCH[i])
      ) slot_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_sel    (slot_wr[i]),
         .wdata     (cfg_wdata),
         .be        (cfg_be),
         .rd_word   (slot_rd[i]),
         .addr_bits (slot_addr[i]),
         .size_mask (slot_mask[i])
      );

      logic [31:0] upper_bits;
      if (i + 1 < SLOT_COUNT) begin : g_has_next
         assign upper_bits = slot_addr[i+1];
      end else begin : g_no_next
         assign upper_bits = 32'h0;
      end

      bar_window_match #(
         .ROLE (ROLE),
         .AW   (AW)
      ) match_i (
         .req_valid (req_valid),
         .req_is_io (req_is_io),
         .req_addr  (req_addr),
         .mem_en    (cmd_mem_en),
         .io_en     (cmd_io_en),
         .lo_addr   (slot_addr[i]),
         .lo_mask   (slot_mask[i]),
         .hi_addr   (upper_bits),
         .hit       (raw_hit[i]),
         .offset    (slot_off[i])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < SLOT_COUNT; i++) begin
         if (cfg_dw == CFG_AW'(SLOT_BASE_DW + i)) cfg_rdata = slot_rd[i];
      end
   end

   always_comb begin
      logic found;
      found      = 1'b0;
      hit_vec    = '0;
      hit_offset = '0;
      for (int i = 0; i < SLOT_COUNT; i++) begin
         if (raw_hit[i] && !found) begin
            found      = 1'b1;
            hit_vec[i] = 1'b1;
            hit_offset = slot_off[i];
         end
      end
   end

   // R10: never more than one slot claims a request
   p_single_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R10: a miss reports a zero offset
   p_miss_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec == '0) |-> (hit_offset == '0));

   // R8: nothing hits without a valid request
   p_valid_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (hit_vec == '0));

   // R8: a disabled space never hits
   p_space_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_is_io && !cmd_io_en) || (!req_is_io && !cmd_mem_en)) |-> (hit_vec == '0));

   // R7: the upper half of a 64-bit pair never reports its own hit
   p_upper_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & upper_map) == '0);

   // R1: offsets outside the slot range read zero
   p_off_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_dw < CFG_AW'(SLOT_BASE_DW)) || (cfg_dw >= CFG_AW'(SLOT_BASE_DW + SLOT_COUNT)))
         |-> (cfg_rdata == 32'h0));

endmodule

// File: tb/bar_decode_bank_tb.sv
`timescale 1ns/1ps
module bar_decode_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [9:0]  cfg_dw = '0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_rdata;
   logic        cmd_mem_en = 1'b0;
   logic        cmd_io_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_is_io = 1'b0;
   logic [63:0] req_addr = '0;
   logic [5:0]  hit_vec;
   logic [63:0] hit_offset;

   int    n_vec = 0;
   int    n_bad = 0;
   string phase = "R5";

   always #2 clk = ~clk;

   bar_decode_bank dut_i (
      .clk, .rst_n, .cfg_wr, .cfg_dw, .cfg_wdata, .cfg_be, .cfg_rdata,
      .cmd_mem_en, .cmd_io_en, .req_valid, .req_is_io, .req_addr,
      .hit_vec, .hit_offset
   );

   // reference model of the default configuration
   int unsigned m_lg   [6] = '{12, 8, 20, 0, 16, 0};
   bit          m_io   [6] = '{0, 1, 0, 0, 0, 0};
   bit          m_wide [6] = '{0, 0, 1, 0, 0, 0};
   bit          m_pf   [6] = '{0, 0, 1, 0, 1, 0};
   logic [31:0] m_reg  [6];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 6; k++) m_reg[k] = 32'h0;
      end else if (cfg_wr && cfg_dw >= 4 && cfg_dw <= 9) begin
         for (int b = 0; b < 4; b++)
            if (cfg_be[b]) m_reg[cfg_dw-4][b*8 +: 8] = cfg_wdata[b*8 +: 8];
      end
   end

   function automatic logic [31:0] m_low_mask(int i);
      logic [63:0] t;
      t = ~((64'd1 << m_lg[i]) - 64'd1);
      return t[31:0];
   endfunction

   function automatic logic [31:0] m_read(int dw);
      int i;
      logic [31:0] a;
      if (dw < 4 || dw > 9) return 32'h0;
      i = dw - 4;
      if (i == 5) return 32'h0;
      if (i == 3) return m_reg[3];
      if (m_io[i]) a = 32'h1;
      else a = {28'h0, m_pf[i], m_wide[i], 2'b00};
      return (m_reg[i] & m_low_mask(i)) | a;
   endfunction

   task automatic m_decode(output logic [5:0] v, output logic [63:0] off);
      logic [63:0] mask, base;
      bit ok;
      v = '0;
      off = '0;
      for (int i = 0; i < 6; i++) begin
         if (i == 3 || i == 5) continue;
         mask = {32'hFFFF_FFFF, m_low_mask(i)};
         base = {(m_wide[i] ? m_reg[i+1] : 32'h0), m_reg[i] & m_low_mask(i)};
         ok = m_io[i] ? (req_is_io && cmd_io_en) : (!req_is_io && cmd_mem_en);
         if (req_valid && ok && ((req_addr & mask) == base) && v == '0) begin
            v[i] = 1'b1;
            off  = req_addr & ~mask;
         end
      end
   endtask

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R9, R10 and R11 in random traffic)
   task automatic tick();
      logic [5:0]  ev;
      logic [63:0] eo;
      @(negedge clk);
      m_decode(ev, eo);
      check({phase, " rdata"}, 64'(cfg_rdata), 64'(m_read(int'(cfg_dw))));
      check({phase, " hit_vec"}, 64'(hit_vec), 64'(ev));
      check({phase, " hit_offset"}, hit_offset, eo);
   endtask

   task automatic cfg_write(int dw, logic [31:0] d, logic [3:0] be);
      cfg_wr = 1'b1; cfg_dw = 10'(dw); cfg_wdata = d; cfg_be = be;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic expect_rd(int dw, logic [31:0] exp, string tag);
      cfg_dw = 10'(dw); phase = tag;
      tick();
      check(tag, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic probe(bit io, logic [63:0] a, logic [5:0] ev, logic [63:0] eo, string tag);
      req_valid = 1'b1; req_is_io = io; req_addr = a; phase = tag;
      tick();
      check({tag, " vec"}, 64'(hit_vec), 64'(ev));
      check({tag, " off"}, hit_offset, eo);
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      // R5 / R2: reset values show only the attribute bits
      expect_rd(4, 32'h0000_0000, "R5 slot0");
      expect_rd(5, 32'h0000_0001, "R2 io attr");
      expect_rd(6, 32'h0000_000C, "R2 wide pf attr");
      expect_rd(7, 32'h0000_0000, "R5 upper");
      expect_rd(8, 32'h0000_0008, "R2 pf attr");
      // R3: all-ones sizing
      for (int d = 4; d <= 9; d++) cfg_write(d, 32'hFFFF_FFFF, 4'hF);
      expect_rd(4, 32'hFFFF_F000, "R3 4k");
      expect_rd(5, 32'hFFFF_FF01, "R3 io 256");
      expect_rd(6, 32'hFFF0_000C, "R3 1m");
      expect_rd(7, 32'hFFFF_FFFF, "R7 upper writable");
      expect_rd(8, 32'hFFFF_0008, "R3 64k");
      expect_rd(9, 32'h0000_0000, "R6 unimplemented");
      // R1: offsets outside the range
      cfg_write(3, 32'h1234_5678, 4'hF);
      expect_rd(3, 32'h0, "R1 below");
      cfg_write(10, 32'h1234_5678, 4'hF);
      expect_rd(10, 32'h0, "R1 above");
      expect_rd(4, 32'hFFFF_F000, "R1 slot0 untouched");
      // program bases
      cfg_write(4, 32'hF302_1000, 4'hF);
      cfg_write(5, 32'h0000_C100, 4'hF);
      cfg_write(6, 32'h2340_0000, 4'hF);
      cfg_write(7, 32'h0000_0001, 4'hF);
      cfg_write(8, 32'h8000_0000, 4'hF);
      // R4: byte enables
      cfg_write(4, 32'hAABB_CCDD, 4'b0100);
      expect_rd(4, 32'hF3BB_1000, "R4 lane2");
      cfg_write(4, 32'hF302_1000, 4'hF);
      cfg_write(4, 32'h0000_00FF, 4'b0001);
      expect_rd(4, 32'hF302_1000, "R4 lane0");
      // R8 disabled spaces
      probe(0, 64'hF302_1ABC, 6'b0, 64'h0, "R8 mem off");
      cmd_mem_en = 1'b1; cmd_io_en = 1'b1;
      // R9 / R11
      probe(0, 64'hF302_1ABC, 6'b000001, 64'hABC, "R11 slot0");
      probe(0, 64'hF302_2000, 6'b0, 64'h0, "R10 above window");
      probe(0, 64'h1_F302_1ABC, 6'b0, 64'h0, "R9 upper bits");
      probe(1, 64'h0000_C1FF, 6'b000010, 64'hFF, "R9 io");
      probe(1, 64'hF302_1ABC, 6'b0, 64'h0, "R8 kind");
      probe(0, 64'h1_234F_FFFF, 6'b000100, 64'hF_FFFF, "R7 wide hit");
      probe(0, 64'h0_234F_FFFF, 6'b0, 64'h0, "R9 wide upper");
      probe(0, 64'h8000_FFFF, 6'b010000, 64'hFFFF, "R11 slot4");
      cmd_io_en = 1'b0;
      probe(1, 64'h0000_C1FF, 6'b0, 64'h0, "R8 io off");
      cmd_io_en = 1'b1;
      req_valid = 1'b0; req_addr = 64'hF302_1ABC; phase = "R8 no valid";
      tick();
      check("R8 no valid", 64'(hit_vec), 64'h0);
      // R10 overlap: slot4 moved over slot0
      cfg_write(8, 32'hF302_0000, 4'hF);
      probe(0, 64'hF302_1ABC, 6'b000001, 64'hABC, "R10 priority");
      probe(0, 64'hF302_0010, 6'b010000, 64'h10, "R10 slot4 only");
      // random traffic against the model
      phase = "R9/R10/R11 random";
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         r = $urandom;
         cfg_wr    = (r[2:0] == 3'd0);
         cfg_dw    = 10'(3 + ($urandom % 8));
         cfg_wdata = (r[3]) ? 32'hFFFF_FFFF : $urandom;
         cfg_be    = 4'($urandom);
         cmd_mem_en = (r[7:4] != 4'd0);
         cmd_io_en  = (r[11:8] != 4'd0);
         req_valid  = r[12] | r[13];
         req_is_io  = r[14] & r[15];
         case (r[17:16])
            2'd0: req_addr = {32'h0, m_reg[0] & 32'hFFFF_F000} | 64'($urandom % 8192);
            2'd1: req_addr = {m_reg[3], m_reg[2] & 32'hFFF0_0000} | 64'($urandom % 2097152);
            2'd2: req_addr = {32'h0, m_reg[1] & 32'hFFFF_FF00} | 64'($urandom % 512);
            default: req_addr = {32'($urandom % 2), 32'($urandom)};
         endcase
         tick();
      end
      cfg_wr = 1'b0;
      req_valid = 1'b0;
      // R5: reset mid-run restores reset values
      rst_n = 1'b0;
      phase = "R5 reset";
      tick();
      rst_n = 1'b1;
      expect_rd(4, 32'h0, "R5 again slot0");
      expect_rd(7, 32'h0, "R5 again upper");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule